// File: doc/BRIEF.md
# Temperature Sensor Register Bank

This block is the register file that sits behind a serial-bus slave in a thermal sensor. The host writes a byte-wide pointer, and the pointer then picks the target of every later word read or word write. The bank holds six 16-bit registers:

- a read-only capability word;
- a configuration word that carries lock, hysteresis, shutdown and event-control fields;
- three temperature limits: upper, lower and critical;
- a read-only temperature word, built from the measurement input and three comparison flags that the block receives.

Register values and a one-cycle clear-event pulse go out on plain outputs to the event logic next door.

Requests come in on one valid/ready channel. An operation code on that channel selects a pointer write, a register write or a register read. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read puts its word on the response channel in the next cycle. `rsp_valid` and `rsp_data` then stay unchanged until a clock edge with `rsp_ready` high. While an unconsumed response is waiting and `rsp_ready` is low, `req_ready` is low and no request of any kind is taken. Pointer and register writes produce no response.

Top module: `tsreg_bank`

## Requirements
- R1: After reset the pointer is 0. Reads give 0x0001 for capability (with the default features parameter) and 0x0000 for configuration, upper, lower and critical. After reset `rsp_valid` and `clr_event` are low and `req_ready` is high.
- R2: Operation codes: 0 is a pointer write using `req_data[7:0]`, 1 is a register write, 2 is a register read. Pointer bits 2:0 select the register: 0 capability, 1 configuration, 2 upper, 3 lower, 4 critical, 5 temperature. Pointer bit 3 is ignored.
- R3: A pointer is unused when any of its bits 7:4 is set or bits 2:0 are 6 or 7. Reads through an unused pointer return 0x0000, and writes through it change no register.
- R4: The capability register is read-only. Bits 4:0 come from a parameter and bits 15:5 read as 0.
- R5: In the upper, lower and critical registers only bits 12:2 are stored. Bits 15:13 and 1:0 always read 0.
- R6: While configuration bit 6 (alarm lock) is set, writes to the upper and lower registers are discarded.
- R7: While configuration bit 7 (critical lock) is set, writes to the critical register are discarded. The alarm lock does not block the critical register.
- R8: Each lock bit is set by writing 1 and is cleared only by reset. Writing 0 to a set lock leaves it set.
- R9: While either lock bit is already set, configuration bits 1:0 (event mode and polarity) keep their value on writes.
- R10: Configuration bit 4 reads the `event_stat_in` input, bit 5 reads 0, and bits 15:11 read 0. Bits 3:0 and 10:8 read back as written.
- R11: A configuration write with bit 5 set drives `clr_event` high for exactly the cycle after the write is accepted.
- R12: The temperature register is read-only and reads as {`flag_crit_in`, `flag_high_in`, `flag_low_in`, `temp_in[12:0]`}, taken when the read is accepted.
- R13: A read's response appears in the cycle after acceptance. It stays valid and stable until `rsp_ready`, and `req_ready` is low while a response is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 pointer write, 1 register write, 2 register read |
| req_data | input | 16 | Pointer in bits 7:0, or write word |
| rsp_valid | output | 1 | Read word present |
| rsp_ready | input | 1 | Host takes the read word |
| rsp_data | output | 16 | Read word |
| temp_in | input | 13 | Measured temperature |
| flag_crit_in | input | 1 | Above-critical flag |
| flag_high_in | input | 1 | Above-window flag |
| flag_low_in | input | 1 | Below-window flag |
| event_stat_in | input | 1 | Event status shown in configuration bit 4 |
| cfg_word | output | 16 | Configuration readback value |
| upper_word | output | 16 | Upper limit |
| lower_word | output | 16 | Lower limit |
| crit_word | output | 16 | Critical limit |
| clr_event | output | 1 | One-cycle clear-event pulse |

## Verification
All-ones writes and values with alternating bits show the reserved and stored bits of each limit apart. The same approach separates the configuration bits that are written from the status bit, which is fed from the input. Pointer values with bit 3 set, with upper bits set, or with codes 6 and 7 tell aliasing apart from discarding. Lock tests follow a fixed order: limits are written, the alarm lock is set, clearing the lock and changing the mode are attempted, and the critical lock is set last. This separates the region each lock guards and shows that locks persist until reset. A stalled response, held for two cycles, shows that the read word is kept and that requests are refused.

// File: rtl/tsreg_pkg.sv
package tsreg_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned PTR_W    = 8;
  localparam int unsigned NUM_REGS = 6;
  localparam int unsigned TEMP_W   = 13;
  localparam int unsigned CAP_W    = 5;

  typedef enum logic [1:0] {
    OP_PTR = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2,
    OP_NOP = 2'd3
  } host_op_e;

  localparam int unsigned SEL_CAP   = 0;
  localparam int unsigned SEL_CFG   = 1;
  localparam int unsigned SEL_UPPER = 2;
  localparam int unsigned SEL_LOWER = 3;
  localparam int unsigned SEL_CRIT  = 4;
  localparam int unsigned SEL_TEMP  = 5;

  localparam int unsigned THR_LSB = 2;
  localparam int unsigned THR_MSB = 12;
endpackage

// File: rtl/tsreg_ptr_dec.sv
module tsreg_ptr_dec
  import tsreg_pkg::*;
#(
  parameter int unsigned P_W = PTR_W,
  parameter int unsigned N_R = NUM_REGS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [P_W-1:0] ptr_in,
  output logic [N_R-1:0] sel
);
  localparam int unsigned IDX_W = 3;

  logic [P_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= ptr_in;
  end

  logic hi_set;
  logic [IDX_W-1:0] idx;
  assign hi_set = |ptr_q[P_W-1:IDX_W+1];
  assign idx    = ptr_q[IDX_W-1:0];

  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(N_R); i++) begin
      if (!hi_set && (int'(idx) == i)) sel[i] = 1'b1;
    end
  end
endmodule

// File: rtl/tsreg_cfg.sv
module tsreg_cfg
  import tsreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              event_stat,
  output logic [WORD_W-1:0] cfg_word,
  output logic              alarm_lock,
  output logic              crit_lock,
  output logic              clr_pulse
);
  logic [1:0] mode_q;
  logic [1:0] ctl_q;
  logic       alock_q, clock_q, shdn_q, clr_q;
  logic [1:0] hyst_q;
  logic       frozen;

  assign frozen = alock_q | clock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ctl_q   <= '0;
      alock_q <= 1'b0;
      clock_q <= 1'b0;
      shdn_q  <= 1'b0;
      hyst_q  <= '0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= wr_en & wdata[5];
      if (wr_en) begin
        if (!frozen) mode_q <= wdata[1:0];
        ctl_q   <= wdata[3:2];
        alock_q <= alock_q | wdata[6];
        clock_q <= clock_q | wdata[7];
        shdn_q  <= wdata[8];
        hyst_q  <= wdata[10:9];
      end
    end
  end

  assign cfg_word   = {5'b0, hyst_q, shdn_q, clock_q, alock_q, 1'b0,
                       event_stat, ctl_q, mode_q};
  assign alarm_lock = alock_q;
  assign crit_lock  = clock_q;
  assign clr_pulse  = clr_q;
endmodule

// File: rtl/tsreg_limit.sv
module tsreg_limit
  import tsreg_pkg::*;
#(
  parameter int unsigned LSB = THR_LSB,
  parameter int unsigned MSB = THR_MSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              lock,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] value
);
  logic [MSB:LSB] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              val_q <= '0;
    else if (wr_en && !lock) val_q <= wdata[MSB:LSB];
  end

  always_comb begin
    value          = '0;
    value[MSB:LSB] = val_q;
  end
endmodule

// File: rtl/tsreg_bank.sv
module tsreg_bank
  import tsreg_pkg::*;
#(
  parameter logic [CAP_W-1:0] CAP_FEATURES = 5'b00001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [WORD_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              flag_crit_in,
  input  logic              flag_high_in,
  input  logic              flag_low_in,
  input  logic              event_stat_in,
  output logic [WORD_W-1:0] cfg_word,
  output logic [WORD_W-1:0] upper_word,
  output logic [WORD_W-1:0] lower_word,
  output logic [WORD_W-1:0] crit_word,
  output logic              clr_event
);
  localparam int unsigned N_LIM = 3;

  logic accept, ptr_wr, reg_wr, reg_rd;
  logic [NUM_REGS-1:0] sel;
  logic alarm_lock, crit_lock;
  logic [WORD_W-1:0] lim_val [N_LIM];
  logic [WORD_W-1:0] cap_word, temp_word, rd_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign ptr_wr    = accept && (req_op == OP_PTR);
  assign reg_wr    = accept && (req_op == OP_WR);
  assign reg_rd    = accept && (req_op == OP_RD);

  tsreg_ptr_dec #(.P_W(PTR_W), .N_R(NUM_REGS)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ptr_wr),
    .ptr_in (req_data[PTR_W-1:0]),
    .sel    (sel)
  );

  tsreg_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr && sel[SEL_CFG]),
    .wdata      (req_data),
    .event_stat (event_stat_in),
    .cfg_word   (cfg_word),
    .alarm_lock (alarm_lock),
    .crit_lock  (crit_lock),
    .clr_pulse  (clr_event)
  );

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    localparam int unsigned SEL_IDX = SEL_UPPER + g;
    logic lim_lock;
    if (SEL_IDX == SEL_CRIT) begin : g_crit
      assign lim_lock = crit_lock;
    end else begin : g_alarm
      assign lim_lock = alarm_lock;
    end
    tsreg_limit #(.LSB(THR_LSB), .MSB(THR_MSB)) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr && sel[SEL_IDX]),
      .lock  (lim_lock),
      .wdata (req_data),
      .value (lim_val[g])
    );
  end

  assign upper_word = lim_val[0];
  assign lower_word = lim_val[1];
  assign crit_word  = lim_val[2];

  assign cap_word  = {{(WORD_W-CAP_W){1'b0}}, CAP_FEATURES};
  assign temp_word = {flag_crit_in, flag_high_in, flag_low_in, temp_in};

  always_comb begin
    rd_word = '0;
    if (sel[SEL_CAP])   rd_word = rd_word | cap_word;
    if (sel[SEL_CFG])   rd_word = rd_word | cfg_word;
    if (sel[SEL_UPPER]) rd_word = rd_word | upper_word;
    if (sel[SEL_LOWER]) rd_word = rd_word | lower_word;
    if (sel[SEL_CRIT])  rd_word = rd_word | crit_word;
    if (sel[SEL_TEMP])  rd_word = rd_word | temp_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (reg_rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tsreg_bank_chk.sv
module tsreg_bank_chk
  import tsreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_data,
  input logic [WORD_W-1:0] cfg_word,
  input logic [WORD_W-1:0] upper_word,
  input logic [WORD_W-1:0] lower_word,
  input logic [WORD_W-1:0] crit_word,
  input logic              clr_event
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R13
  AST_STALL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R13
  AST_ALARM_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_word[6]) |-> $stable(upper_word) && $stable(lower_word)); // R6
  AST_CRIT_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_word[7]) |-> $stable(crit_word)); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfg_word[6]) && !$fell(cfg_word[7])); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_word[7] | cfg_word[6]) |-> $stable(cfg_word[1:0])); // R9
  AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_event |-> $past(req_valid && req_ready && req_op == OP_WR)); // R11
endmodule

bind tsreg_bank tsreg_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .cfg_word   (cfg_word),
  .upper_word (upper_word),
  .lower_word (lower_word),
  .crit_word  (crit_word),
  .clr_event  (clr_event)
);

// File: tb/tsreg_bank_tb.sv
module tsreg_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [15:0] req_data = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [12:0] temp_in = '0;
  logic flag_crit_in = 1'b0, flag_high_in = 1'b0, flag_low_in = 1'b0;
  logic event_stat_in = 1'b0;
  logic [15:0] cfg_word, upper_word, lower_word, crit_word;
  logic clr_event;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .temp_in(temp_in),
    .flag_crit_in(flag_crit_in), .flag_high_in(flag_high_in),
    .flag_low_in(flag_low_in), .event_stat_in(event_stat_in),
    .cfg_word(cfg_word), .upper_word(upper_word), .lower_word(lower_word),
    .crit_word(crit_word), .clr_event(clr_event)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [1:0] op, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] ptr, input logic [15:0] val);
    xact(2'd0, {8'h00, ptr});
    xact(2'd1, val);
  endtask

  task automatic rd_reg(input logic [7:0] ptr, input logic [15:0] exp, input string tag);
    xact(2'd0, {8'h00, ptr});
    xact(2'd2, 16'h0000);
    check({tag, " rsp_valid"}, {15'd0, rsp_valid}, 16'd1);
    check(tag, rsp_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    check("R1 req_ready", {15'd0, req_ready}, 16'd1);
    check("R1 clr_event", {15'd0, clr_event}, 16'd0);
    xact(2'd2, 16'h0000);
    check("R1 default pointer reads capability", rsp_data, 16'h0001);
    rd_reg(8'h01, 16'h0000, "R1 cfg default");
    rd_reg(8'h02, 16'h0000, "R1 upper default");
    rd_reg(8'h03, 16'h0000, "R1 lower default");
    rd_reg(8'h04, 16'h0000, "R1 crit default");
  endtask

  task automatic t_select();
    wr_reg(8'h02, 16'h1234);
    rd_reg(8'h02, 16'h1234, "R2 upper select");
    check("R2 upper port", upper_word, 16'h1234);
    wr_reg(8'h03, 16'hFFFF);
    rd_reg(8'h03, 16'h1FFC, "R5 lower all-ones masked");
    wr_reg(8'h04, 16'h0AAB);
    rd_reg(8'h04, 16'h0AA8, "R5 crit low bits dropped");
    rd_reg(8'h0A, 16'h1234, "R2 pointer bit3 ignored");
  endtask

  task automatic t_unused();
    rd_reg(8'h06, 16'h0000, "R3 pointer 6");
    rd_reg(8'h07, 16'h0000, "R3 pointer 7");
    rd_reg(8'h12, 16'h0000, "R3 pointer 0x12");
    wr_reg(8'h12, 16'hFFFF);
    rd_reg(8'h02, 16'h1234, "R3 write via unused pointer discarded");
  endtask

  task automatic t_readonly();
    wr_reg(8'h00, 16'hFFFF);
    rd_reg(8'h00, 16'h0001, "R4 capability read-only");
    temp_in = 13'h0ABC; flag_crit_in = 1'b1; flag_high_in = 1'b0; flag_low_in = 1'b1;
    rd_reg(8'h05, 16'hAABC, "R12 temperature word");
    wr_reg(8'h05, 16'h0000);
    rd_reg(8'h05, 16'hAABC, "R12 temperature write ignored");
  endtask

  task automatic t_cfg_fields();
    event_stat_in = 1'b1;
    wr_reg(8'h01, 16'hFF3F);
    check("R11 clr pulse high", {15'd0, clr_event}, 16'd1);
    @(negedge clk);
    check("R11 clr pulse one cycle", {15'd0, clr_event}, 16'd0);
    rd_reg(8'h01, 16'h071F, "R10 cfg fields, status=1");
    event_stat_in = 1'b0;
    rd_reg(8'h01, 16'h070F, "R10 cfg status follows input");
    wr_reg(8'h01, 16'h0000);
    check("R11 no pulse without bit5", {15'd0, clr_event}, 16'd0);
    rd_reg(8'h01, 16'h0000, "R10 cfg cleared");
  endtask

  task automatic t_locks();
    wr_reg(8'h02, 16'h0100);
    wr_reg(8'h03, 16'h0040);
    wr_reg(8'h04, 16'h0200);
    wr_reg(8'h01, 16'h0041);
    rd_reg(8'h01, 16'h0041, "R8 alarm lock set");
    wr_reg(8'h01, 16'h0002);
    rd_reg(8'h01, 16'h0041, "R8 R9 lock kept, mode frozen");
    wr_reg(8'h02, 16'h0800);
    rd_reg(8'h02, 16'h0100, "R6 upper locked");
    wr_reg(8'h03, 16'h0800);
    rd_reg(8'h03, 16'h0040, "R6 lower locked");
    wr_reg(8'h04, 16'h0300);
    rd_reg(8'h04, 16'h0300, "R7 crit open under alarm lock");
    wr_reg(8'h01, 16'h0080);
    rd_reg(8'h01, 16'h00C1, "R8 crit lock added");
    wr_reg(8'h04, 16'h0400);
    rd_reg(8'h04, 16'h0300, "R7 crit locked");
  endtask

  task automatic t_backpressure();
    xact(2'd0, 16'h0000);
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd2; req_data = '0;
    @(negedge clk);
    req_op = 2'd0; req_data = 16'h0002;
    check("R13 rsp valid next cycle", {15'd0, rsp_valid}, 16'd1);
    check("R13 rsp data", rsp_data, 16'h0001);
    check("R13 req refused while stalled", {15'd0, req_ready}, 16'd0);
    @(negedge clk);
    check("R13 rsp held", rsp_data, 16'h0001);
    check("R13 valid held", {15'd0, rsp_valid}, 16'd1);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R13 rsp drained", {15'd0, rsp_valid}, 16'd0);
    xact(2'd2, 16'h0000);
    check("R13 stalled pointer write not taken", rsp_data, 16'h0001);
  endtask

  task automatic t_reset_clears_locks();
    do_reset();
    rd_reg(8'h01, 16'h0000, "R8 locks cleared only by reset");
    wr_reg(8'h02, 16'h0FF0);
    rd_reg(8'h02, 16'h0FF0, "R6 upper writable after reset");
  endtask

  initial begin
    t_reset();
    t_select();
    t_unused();
    t_readonly();
    t_cfg_fields();
    t_backpressure();
    t_locks();
    t_reset_clears_locks();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule